// File: doc/BRIEF.md
# Prioritized Interrupt Request and Service Tracker

This block keeps two bitmaps over all 256 interrupt vectors. One holds the requests that are waiting, and the other holds the requests the core is handling now. Each cycle it finds the highest waiting vector. It then derives a processor priority from the task priority value and the top vector in service, and drives a registered interrupt line to the core when the waiting vector's priority class beats that processor priority.

The core answers the line with an acknowledge pulse. One cycle later the block reports the granted vector and moves it from waiting to in service. An end-of-interrupt pulse retires the highest in-service vector. Simple set and clear ports raise and withdraw requests.

A legacy external-interrupt input can also drive the line. It counts only while the local line is configured to accept external delivery. An accepted external request skips all priority arbitration, and its acknowledge reports "no vector" so that the external controller supplies one.

Top module: `irq_prio_tracker`

## Requirements
- R1: After a synchronous reset, both bitmaps are empty, the task priority is 0, and `irq_out`, `ack_vld`, `ack_none`, `ack_vec` and `ppr_out` are 0.
- R2: Vector v is stored at bit v of each 256-bit map (word v/32, bit v mod 32). When several vectors are waiting, an acknowledge grants the highest-numbered one.
- R3: While `sw_en` is low, no waiting vector raises `irq_out`, and an acknowledge returns `ack_none`=1 with both maps unchanged.
- R4: `tpr_class` shows bits [7:4] of the last value written through `tpr_wr`, starting the cycle after the write.
- R5: An acknowledge that grants a vector gives `ack_vld`=1, `ack_none`=0 and `ack_vec`= that vector one cycle later. In the same cycle it clears the waiting bit and sets the in-service bit. Whenever `ack_none`=1, `ack_vec` is 0.
- R6: When `ext_req` and `lint0_ext` are both high, `irq_out` rises regardless of priority or `sw_en`. An acknowledge then returns `ack_none`=1 and changes neither map.
- R7: The processor priority (`ppr_out`) equals the task priority when the in-service map is empty or its top vector's bits [7:4] do not exceed the task priority's bits [7:4]. Otherwise it equals that top vector with bits [3:0] cleared.
- R8: A waiting vector is deliverable only when its bits [7:4] are strictly greater than bits [7:4] of the processor priority.
- R9: An end-of-interrupt pulse clears the highest set in-service bit, and `irq_out` reflects the new state one cycle after the update.
- R10: `irq_out` is low when nothing deliverable is waiting and no accepted external request is present.
- R11: A clear pulse withdraws the named waiting vector. A set and a clear in the same cycle leave the clear in effect when both name the same vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_en | input | 1 | Software enable for prioritized delivery |
| ext_req | input | 1 | Legacy external interrupt request level |
| lint0_ext | input | 1 | Local line configured to accept external delivery |
| set_vld | input | 1 | Raise the request named by set_vec |
| set_vec | input | 8 | Vector to raise |
| clr_vld | input | 1 | Withdraw the request named by clr_vec |
| clr_vec | input | 8 | Vector to withdraw |
| tpr_wr | input | 1 | Write task priority |
| tpr_in | input | 8 | Task priority value |
| ack | input | 1 | Interrupt acknowledge pulse from the core |
| eoi | input | 1 | End-of-interrupt pulse |
| irq_out | output | 1 | Registered interrupt request to the core |
| ack_vld | output | 1 | Acknowledge response valid |
| ack_none | output | 1 | Acknowledge produced no vector |
| ack_vec | output | 8 | Granted vector |
| ppr_out | output | 8 | Registered processor priority |
| tpr_class | output | 4 | Upper four bits of task priority |

## Verification
`irq_out`, `ppr_out` and the acknowledge response are each registered once. They show the result of the state and inputs present at the stimulus edge, one edge later. `tpr_class` and both maps take their new values at that same edge. The bench drives each stimulus on a falling edge and computes every expectation from its model's state before the rising edge. It samples on the next falling edge and only then advances the model, so no result is read a cycle early or late.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NVEC_DEF  = 256;
  localparam int WORD_BITS = 32;
  localparam int CLASS_W   = 4;
endpackage

// File: rtl/irq_prio_find.sv
module irq_prio_find #(
  parameter int N    = irq_pkg::NVEC_DEF,
  parameter int WORD = irq_pkg::WORD_BITS
) (
  input  logic [N-1:0]         bits,
  output logic                 found,
  output logic [$clog2(N)-1:0] idx
);
  localparam int W  = $clog2(N);
  localparam int NW = N / WORD;
  localparam int LW = $clog2(WORD);

  logic [NW-1:0]         w_any;
  logic [NW-1:0][LW-1:0] w_idx;

  for (genvar g = 0; g < NW; g++) begin : g_word
    logic [LW-1:0] loc;
    always_comb begin
      loc = '0;
      for (int b = 0; b < WORD; b++)
        if (bits[g*WORD+b]) loc = LW'(b);
    end
    assign w_idx[g] = loc;
    assign w_any[g] = |bits[g*WORD +: WORD];
  end

  always_comb begin
    found = |w_any;
    idx   = '0;
    for (int w = 0; w < NW; w++)
      if (w_any[w]) idx = W'(w*WORD + int'(w_idx[w]));
  end

  always_comb begin
    if (found) begin
      AST_FIND_HIGHEST: assert ((bits >> idx) == N'(1)); // R2
    end
  end
endmodule

// File: rtl/irq_ppr_calc.sv
module irq_ppr_calc #(
  parameter int VW = 8
) (
  input  logic [VW-1:0] tpr,
  input  logic          isr_found,
  input  logic [VW-1:0] isr_top,
  output logic [VW-1:0] ppr
);
  localparam int CW = irq_pkg::CLASS_W;

  always_comb begin
    if (!isr_found || tpr[VW-1 -: CW] >= isr_top[VW-1 -: CW])
      ppr = tpr;
    else
      ppr = {isr_top[VW-1 -: CW], {(VW-CW){1'b0}}};
  end

  always_comb begin
    AST_PPR_FLOOR: assert (ppr[VW-1 -: CW] >= tpr[VW-1 -: CW]); // R7
  end
endmodule

// File: rtl/irq_prio_tracker.sv
module irq_prio_tracker #(
  parameter int NVEC = irq_pkg::NVEC_DEF,
  localparam int VW  = $clog2(NVEC),
  localparam int CW  = irq_pkg::CLASS_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sw_en,
  input  logic          ext_req,
  input  logic          lint0_ext,
  input  logic          set_vld,
  input  logic [VW-1:0] set_vec,
  input  logic          clr_vld,
  input  logic [VW-1:0] clr_vec,
  input  logic          tpr_wr,
  input  logic [VW-1:0] tpr_in,
  input  logic          ack,
  input  logic          eoi,
  output logic          irq_out,
  output logic          ack_vld,
  output logic          ack_none,
  output logic [VW-1:0] ack_vec,
  output logic [VW-1:0] ppr_out,
  output logic [CW-1:0] tpr_class
);
  logic [NVEC-1:0] irr_q, isr_q, irr_n, isr_n;
  logic [VW-1:0]   tpr_q, irr_top, isr_top, ppr;
  logic            irr_found, isr_found;
  logic            ext_ok, deliver, grant;
  logic            irq_q, ack_vld_q, ack_none_q;
  logic [VW-1:0]   ack_vec_q, ppr_q;

  irq_prio_find #(.N(NVEC)) u_irr_find (.bits(irr_q), .found(irr_found), .idx(irr_top));
  irq_prio_find #(.N(NVEC)) u_isr_find (.bits(isr_q), .found(isr_found), .idx(isr_top));
  irq_ppr_calc  #(.VW(VW))  u_ppr (.tpr(tpr_q), .isr_found(isr_found), .isr_top(isr_top), .ppr(ppr));

  assign ext_ok  = ext_req && lint0_ext;
  assign deliver = sw_en && irr_found && (irr_top[VW-1 -: CW] > ppr[VW-1 -: CW]);
  assign grant   = ack && !ext_ok && deliver;

  always_comb begin
    irr_n = irr_q;
    if (set_vld) irr_n[set_vec] = 1'b1;
    if (clr_vld) irr_n[clr_vec] = 1'b0;
    if (grant)   irr_n[irr_top] = 1'b0;
  end

  always_comb begin
    isr_n = isr_q;
    if (eoi && isr_found) isr_n[isr_top] = 1'b0;
    if (grant)            isr_n[irr_top] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irr_q      <= '0;
      isr_q      <= '0;
      tpr_q      <= '0;
      irq_q      <= 1'b0;
      ack_vld_q  <= 1'b0;
      ack_none_q <= 1'b0;
      ack_vec_q  <= '0;
      ppr_q      <= '0;
    end else begin
      irr_q      <= irr_n;
      isr_q      <= isr_n;
      if (tpr_wr) tpr_q <= tpr_in;
      irq_q      <= ext_ok || deliver;
      ack_vld_q  <= ack;
      ack_none_q <= ack && !grant;
      ack_vec_q  <= grant ? irr_top : '0;
      ppr_q      <= ppr;
    end
  end

  assign irq_out   = irq_q;
  assign ack_vld   = ack_vld_q;
  assign ack_none  = ack_none_q;
  assign ack_vec   = ack_vec_q;
  assign ppr_out   = ppr_q;
  assign tpr_class = tpr_q[VW-1 -: CW];

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    (!sw_en && !ext_ok) |=> !irq_out); // R3
  AST_EXT_NO_VECTOR: assert property (@(posedge clk) disable iff (rst)
    (ack && ext_ok) |=> (ack_vld && ack_none)); // R6
  AST_TPR_CLASS: assert property (@(posedge clk) disable iff (rst)
    tpr_wr |=> (tpr_class == $past(tpr_in[VW-1 -: CW]))); // R4
  AST_NONE_ZERO_VEC: assert property (@(posedge clk) disable iff (rst)
    ack_none |-> (ack_vec == '0)); // R5
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    (!ext_ok && !irr_found) |=> !irq_out); // R10
endmodule

// File: tb/sim_irq_prio_tracker.sv
`timescale 1ns/1ps
module sim_irq_prio_tracker;
  logic clk = 1'b0, rst = 1'b1;
  logic sw_en = 0, ext_req = 0, lint0_ext = 0;
  logic set_vld = 0, clr_vld = 0, tpr_wr = 0, ack = 0, eoi = 0;
  logic [7:0] set_vec = 0, clr_vec = 0, tpr_in = 0;
  logic irq_out, ack_vld, ack_none;
  logic [7:0] ack_vec, ppr_out;
  logic [3:0] tpr_class;

  int n_chk = 0, n_err = 0;
  logic [255:0] irr_m = '0, isr_m = '0;
  logic [7:0]   tpr_m = '0;

  always #2.5 clk = ~clk;

  irq_prio_tracker u0 (.clk(clk), .rst(rst), .sw_en(sw_en), .ext_req(ext_req),
    .lint0_ext(lint0_ext), .set_vld(set_vld), .set_vec(set_vec), .clr_vld(clr_vld),
    .clr_vec(clr_vec), .tpr_wr(tpr_wr), .tpr_in(tpr_in), .ack(ack), .eoi(eoi),
    .irq_out(irq_out), .ack_vld(ack_vld), .ack_none(ack_none), .ack_vec(ack_vec),
    .ppr_out(ppr_out), .tpr_class(tpr_class));

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [8:0] hi(logic [255:0] b);
    logic [8:0] r = '0;
    for (int i = 0; i < 256; i++) if (b[i]) r = {1'b1, 8'(i)};
    return r;
  endfunction

  function automatic logic [7:0] ppr_f(logic [7:0] t, logic [255:0] s);
    logic [8:0] h = hi(s);
    if (!h[8] || t[7:4] >= h[7:4]) return t;
    return {h[7:4], 4'h0};
  endfunction

  task automatic cyc(string tag, bit s, bit [7:0] sv, bit c, bit [7:0] cv,
                     bit tw, bit [7:0] tv, bit a, bit e);
    logic [8:0] ih;
    logic [7:0] pp;
    bit ext, dlv, gr;
    set_vld = s; set_vec = sv; clr_vld = c; clr_vec = cv;
    tpr_wr = tw; tpr_in = tv; ack = a; eoi = e;
    ih  = hi(irr_m);
    pp  = ppr_f(tpr_m, isr_m);
    ext = ext_req && lint0_ext;
    dlv = sw_en && ih[8] && (ih[7:4] > pp[7:4]);
    gr  = a && !ext && dlv;
    @(posedge clk);
    @(negedge clk);
    set_vld = 0; clr_vld = 0; tpr_wr = 0; ack = 0; eoi = 0;
    if (s) irr_m[sv] = 1'b1;
    if (c) irr_m[cv] = 1'b0;
    if (gr) irr_m[ih[7:0]] = 1'b0;
    if (e && hi(isr_m) > 0) isr_m[hi(isr_m) & 9'hFF] = 1'b0;
    if (gr) isr_m[ih[7:0]] = 1'b1;
    if (tw) tpr_m = tv;
    chk(tag, "irq_out R8",   int'(irq_out),   int'(ext || dlv));
    chk(tag, "ack_vld R5",   int'(ack_vld),   int'(a));
    chk(tag, "ack_none R6",  int'(ack_none),  int'(a && !gr));
    chk(tag, "ack_vec R2",   int'(ack_vec),   gr ? int'(ih[7:0]) : 0);
    chk(tag, "ppr_out R7",   int'(ppr_out),   int'(pp));
    chk(tag, "tpr_class R4", int'(tpr_class), int'(tpr_m[7:4]));
  endtask

  initial begin
    #(5.0 * 200000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    chk("R1", "irq_out", int'(irq_out), 0);
    chk("R1", "ack_vld", int'(ack_vld), 0);
    chk("R1", "ppr_out", int'(ppr_out), 0);
    chk("R1", "tpr_class", int'(tpr_class), 0);
    // R3: disabled, pending does not interrupt, ack gives none
    sw_en = 0;
    cyc("R3", 1, 8'h80, 0, 0, 0, 0, 0, 0);
    cyc("R3", 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R3", 0, 0, 0, 0, 0, 0, 1, 0);
    sw_en = 1;
    cyc("R8", 0, 0, 0, 0, 0, 0, 0, 0);
    // R8: equal class with TPR is not delivered
    cyc("R8", 0, 0, 0, 0, 1, 8'h80, 0, 0);
    cyc("R8", 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R8", 0, 0, 0, 0, 1, 8'h7F, 0, 0);
    cyc("R5", 0, 0, 0, 0, 0, 0, 1, 0);
    // R7: in-service class masks same class
    cyc("R7", 1, 8'h85, 0, 0, 0, 0, 0, 0);
    cyc("R7", 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R9", 0, 0, 0, 0, 0, 0, 0, 1);
    cyc("R9", 0, 0, 0, 0, 0, 0, 0, 0);
    // R11 / R10: withdraw and line drops
    cyc("R11", 1, 8'h85, 1, 8'h85, 0, 0, 0, 0);
    cyc("R11", 0, 0, 1, 8'h85, 0, 0, 0, 0);
    cyc("R10", 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R10", 0, 0, 0, 0, 0, 0, 0, 0);
    // R6: accepted external request bypasses priority
    ext_req = 1; lint0_ext = 1; sw_en = 0;
    cyc("R6", 1, 8'h90, 0, 0, 1, 8'hFF, 0, 0);
    cyc("R6", 0, 0, 0, 0, 0, 0, 1, 0);
    cyc("R6", 0, 0, 0, 0, 0, 0, 0, 0);
    ext_req = 0; lint0_ext = 0; sw_en = 1;
    // R2: highest-numbered wins
    cyc("R2", 0, 0, 0, 0, 1, 8'h00, 0, 0);
    cyc("R2", 1, 8'h10, 0, 0, 0, 0, 0, 0);
    cyc("R2", 1, 8'hF3, 0, 0, 0, 0, 0, 0);
    cyc("R2", 1, 8'h22, 0, 0, 0, 0, 0, 0);
    cyc("R2", 0, 0, 0, 0, 0, 0, 1, 0);
    for (int n = 0; n < 4000; n++) begin
      int op = int'($urandom_range(0, 99));
      if (op < 35)      cyc("R2", 1, 8'($urandom), 0, 0, 0, 0, 0, 0);
      else if (op < 40) cyc("R11", 0, 0, 1, 8'($urandom), 0, 0, 0, 0);
      else if (op < 62) cyc("R5", 0, 0, 0, 0, 0, 0, 1, 0);
      else if (op < 80) cyc("R9", 0, 0, 0, 0, 0, 0, 0, 1);
      else if (op < 90) cyc("R7", 0, 0, 0, 0, 1, 8'($urandom_range(0, 159)), 0, 0);
      else if (op < 93) begin sw_en = ~sw_en; cyc("R3", 0, 0, 0, 0, 0, 0, 0, 0); end
      else if (op < 97) begin ext_req = ~ext_req; cyc("R6", 0, 0, 0, 0, 0, 0, 1, 0); end
      else begin lint0_ext = ~lint0_ext; cyc("R10", 0, 0, 0, 0, 0, 0, 0, 0); end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule